// File: doc/BRIEF.md
# Frame Pixel Grabber

This block lets a host pull a full image out of a square sensor array through a single 8-bit register, at a rate of one pixel per frame. The pixel stream from the array passes the block every frame. Each pixel comes with its index and a 7-bit value. The block keeps an internal pixel counter and waits for the start of a frame. In that frame it latches the one pixel whose index equals the counter and then holds it until the host reads it.

A read returns the held pixel with the top bit set. That read also moves the counter to the next index and arms the block for the following frame. A read made while nothing is held returns zero and changes nothing. A write of any value sends the counter back to pixel 0 and arms the block again. With the default 15 by 15 array, a complete image takes 225 successful reads spread over at least 225 frames.

Top module: `pixel_grabber`

## Requirements
- R1: After reset the register reads 0x00, and the counter points at pixel 0 with the block armed.
- R2: The register value is {valid, pixel[6:0]}, with valid in bit 7. While bit 7 is 0, bits 6..0 also read 0.
- R3: A capture takes only the pixel whose index equals the internal counter. Pixels with other indices are ignored.
- R4: A capture happens only after a frame-start pulse that follows arming. A pixel presented while armed but before that pulse is ignored, and so is a pixel in the same cycle as a frame-start pulse.
- R5: Once a pixel is held, the register value does not change until a read or a write, whatever frames and pixels arrive.
- R6: A read that finds bit 7 set returns the held pixel. From the next cycle the register reads 0x00, the counter moves to the next index, and the block waits for a new frame.
- R7: A read that finds bit 7 clear returns 0x00 and leaves the counter unchanged.
- R8: Any write clears the held pixel, sets the counter to 0 and arms the block. When a read and a write arrive in the same cycle, the read returns the current value and the write decides the counter.
- R9: After pixel 224 has been read the counter wraps to 0, so 225 successful reads walk through the whole array once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse marking the start of a frame |
| pixValid | input | 1 | A pixel is present on pixIdx/pixData this cycle |
| pixIdx | input | 8 | Index of the current pixel, 0 to 224 |
| pixData | input | 7 | Value of the current pixel |
| regRd | input | 1 | Register read strobe, one cycle |
| regWr | input | 1 | Register write strobe, one cycle |
| regData | output | 8 | Register value {valid, pixel} |

## Verification
Every frame carries a full 0..224 stream whose values depend on both the index and a per-frame seed. The value returned by a read therefore shows which index was taken and from which frame. Extra frames arrive while a pixel is held, to show that the first capture is kept. Reads arrive while nothing is held, to show that the counter does not move. Some pixel patterns arrive with no frame-start pulse, or share their cycle with that pulse, to show that neither is taken. A complete 225-read sweep followed by one more frame shows the walk in index order and the wrap. A read and a write in the same cycle shows that the write wins.

// File: rtl/grab_pkg.sv
`timescale 1ns/1ps
package grab_pkg;
  typedef enum logic [1:0] {
    GRAB_ARMED,   // waiting for a frame boundary
    GRAB_HUNT,    // frame in progress, looking for the target index
    GRAB_HELD     // pixel latched, waiting for the host
  } grabState_t;

  typedef struct packed {
    logic clearIdx;   // counter back to pixel 0
    logic stepIdx;    // counter to the next pixel, with wrap
    logic latchPix;   // store the incoming pixel value
  } grabCtl_t;
endpackage

// File: rtl/grab_datapath.sv
`timescale 1ns/1ps
module grab_datapath
  import grab_pkg::*;
#(
  parameter int PIX_W    = 7,
  parameter int IDX_W    = 8,
  parameter int LAST_IDX = 224
) (
  input  logic             clk,
  input  logic             rstN,
  input  grabCtl_t         ctl,
  input  logic             pixValid,
  input  logic [IDX_W-1:0] pixIdx,
  input  logic [PIX_W-1:0] pixData,
  output logic             idxMatch,
  output logic [PIX_W-1:0] heldPix
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LAST_IDX);

  logic [IDX_W-1:0] pixCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt <= '0;
    end else if (ctl.clearIdx) begin
      pixCnt <= '0;
    end else if (ctl.stepIdx) begin
      pixCnt <= (pixCnt == LAST) ? '0 : pixCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldPix <= '0;
    end else if (ctl.latchPix) begin
      heldPix <= pixData;
    end
  end

  assign idxMatch = pixValid && (pixIdx == pixCnt);
endmodule

// File: rtl/grab_control.sv
`timescale 1ns/1ps
module grab_control
  import grab_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     frameStart,
  input  logic     idxMatch,
  input  logic     regRd,
  input  logic     regWr,
  output grabCtl_t ctl,
  output logic     holdValid
);
  grabState_t state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= GRAB_ARMED;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    if (regWr) begin
      ctl.clearIdx = 1'b1;
      nextState    = GRAB_ARMED;
    end else begin
      unique case (state)
        GRAB_ARMED: if (frameStart) nextState = GRAB_HUNT;
        GRAB_HUNT: begin
          if (idxMatch && !frameStart) begin
            ctl.latchPix = 1'b1;
            nextState    = GRAB_HELD;
          end
        end
        GRAB_HELD: begin
          if (regRd) begin
            ctl.stepIdx = 1'b1;
            nextState   = GRAB_ARMED;
          end
        end
        default: nextState = GRAB_ARMED;
      endcase
    end
  end

  assign holdValid = (state == GRAB_HELD);
endmodule

// File: rtl/pixel_grabber.sv
`timescale 1ns/1ps
module pixel_grabber
  import grab_pkg::*;
#(
  parameter int ARRAY_DIM = 15,
  parameter int PIX_W     = 7,
  localparam int NUM_PIX  = ARRAY_DIM * ARRAY_DIM,
  localparam int IDX_W    = $clog2(NUM_PIX),
  localparam int REG_W    = PIX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameStart,
  input  logic             pixValid,
  input  logic [IDX_W-1:0] pixIdx,
  input  logic [PIX_W-1:0] pixData,
  input  logic             regRd,
  input  logic             regWr,
  output logic [REG_W-1:0] regData
);
  grabCtl_t         ctl;
  logic             idxMatch;
  logic             holdValid;
  logic [PIX_W-1:0] heldPix;

  grab_control u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .idxMatch(idxMatch),
    .regRd(regRd), .regWr(regWr), .ctl(ctl), .holdValid(holdValid)
  );

  grab_datapath #(.PIX_W(PIX_W), .IDX_W(IDX_W), .LAST_IDX(NUM_PIX - 1)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pixValid(pixValid), .pixIdx(pixIdx),
    .pixData(pixData), .idxMatch(idxMatch), .heldPix(heldPix)
  );

  assign regData = holdValid ? {1'b1, heldPix} : '0;
endmodule

// File: rtl/grab_checker.sv
`timescale 1ns/1ps
module grab_checker #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             frameStart,
  input logic             pixValid,
  input logic             regRd,
  input logic             regWr,
  input logic [REG_W-1:0] regData
);
  localparam int TOP = REG_W - 1;

  assert_reset_value_R1: assert property (@(posedge clk)
    !rstN |=> regData == '0);

  assert_blank_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    !regData[TOP] |-> regData[TOP-1:0] == '0);

  assert_needs_pixel_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regData[TOP]) |-> $past(pixValid));

  assert_no_frame_cycle_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regData[TOP]) |-> !$past(frameStart));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    regData[TOP] && !regRd && !regWr |=> $stable(regData));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    regRd && regData[TOP] |=> !regData[TOP]);

  assert_write_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    regWr |=> !regData[TOP]);
endmodule

bind pixel_grabber grab_checker #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixValid(pixValid),
  .regRd(regRd), .regWr(regWr), .regData(regData)
);

// File: tb/pixel_grabber_test.sv
`timescale 1ns/1ps
module pixel_grabber_test;
  localparam int NPIX = 225;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameStart = 1'b0;
  logic       pixValid = 1'b0;
  logic [7:0] pixIdx = '0;
  logic [6:0] pixData = '0;
  logic       regRd = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regData;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #2.5 clk = ~clk;

  pixel_grabber uut (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .pixValid(pixValid),
    .pixIdx(pixIdx), .pixData(pixData), .regRd(regRd), .regWr(regWr),
    .regData(regData)
  );

  function automatic logic [6:0] pixVal(int idx, int seed);
    return 7'((idx * 5 + seed * 11) & 8'h7F);
  endfunction

  // monitor: compare every read against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (regRd) begin
        logic [7:0] e;
        string t;
        vectors++;
        if (expQ.size() == 0) begin
          miscompares++;
          $display("FAIL unexpected read: actual %02h expected none", regData);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (regData !== e) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", t, regData, e);
          end
        end
      end
    end
  end

  task automatic hostRead(input logic [7:0] e, input string t);
    @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(t);
    regRd = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic hostWrite();
    @(negedge clk);
    regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic hostReadWrite(input logic [7:0] e, input string t);
    @(negedge clk);
    expQ.push_back(e);
    tagQ.push_back(t);
    regRd = 1'b1;
    regWr = 1'b1;
    @(negedge clk);
    regRd = 1'b0;
    regWr = 1'b0;
  endtask

  task automatic doFrame(input int seed);
    @(negedge clk);
    frameStart = 1'b1;
    pixValid   = 1'b0;
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      frameStart = 1'b0;
      pixValid   = 1'b1;
      pixIdx     = 8'(i);
      pixData    = pixVal(i, seed);
    end
    @(negedge clk);
    pixValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 / R7: reset value, empty read
    hostRead(8'h00, "R1 reset value");
    // R4: pixels without a frame-start are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      pixValid = 1'b1;
      pixIdx   = 8'(i);
      pixData  = 7'h55;
    end
    @(negedge clk);
    pixValid = 1'b0;
    hostRead(8'h00, "R4 no capture before frame start");
    // R3 / R2: first frame captures pixel 0
    doFrame(1);
    // R5: a second frame does not replace the held pixel
    doFrame(2);
    hostRead({1'b1, pixVal(0, 1)}, "R3 R5 pixel 0 of first frame kept");
    // R6: cleared after a successful read
    hostRead(8'h00, "R6 cleared after read");
    // R7 / R6: empty read did not advance, so index 1 comes next
    doFrame(3);
    hostRead({1'b1, pixVal(1, 3)}, "R7 R6 index 1 after one valid read");
    // R8: write returns to pixel 0
    hostWrite();
    doFrame(4);
    hostRead({1'b1, pixVal(0, 4)}, "R8 write resets to pixel 0");
    // R9: full sweep then wrap
    hostWrite();
    for (int i = 0; i < NPIX; i++) begin
      doFrame(5 + (i % 3));
      hostRead({1'b1, pixVal(i, 5 + (i % 3))}, $sformatf("R9 sweep index %0d", i));
    end
    doFrame(9);
    hostRead({1'b1, pixVal(0, 9)}, "R9 wrap to pixel 0");
    // R4: pixel sharing its cycle with frame-start is not taken (counter now 1)
    @(negedge clk);
    frameStart = 1'b1;
    pixValid   = 1'b1;
    pixIdx     = 8'd1;
    pixData    = 7'h2A;
    @(negedge clk);
    frameStart = 1'b0;
    pixValid   = 1'b0;
    @(negedge clk);
    hostRead(8'h00, "R4 pixel in frame-start cycle ignored");
    // R8: simultaneous read and write, write decides the counter
    doFrame(10);
    hostReadWrite({1'b1, pixVal(1, 10)}, "R8 read value with simultaneous write");
    hostRead(8'h00, "R8 cleared after write");
    doFrame(11);
    hostRead({1'b1, pixVal(0, 11)}, "R8 counter at 0 after read+write");
    repeat (4) @(negedge clk);
    if (expQ.size() != 0) begin
      miscompares++;
      $display("FAIL scoreboard: actual %0d pending expected 0", expQ.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule